// File: doc/BRIEF.md
# AXI ID-Filtered Event Generator

This block watches an AXI-like monitor tap on a memory port and turns three kinds of handshake into single-cycle event pulses: the start of a read transaction (address-read channel), the start of a write transaction (address-write channel) and each read data beat (read-data channel). A handshake is reported only when its transaction ID matches a programmed reference ID under a programmed mask, and only when the filter for that event kind is enabled. The three pulses feed a counter bank. The read-transaction pulse goes to counter 2, the write-transaction pulse to counter 3 and the read-beat pulse to counter 4. In each case it takes the place of event 73 on that counter.

The tap is passive. The block only observes valid and ready; it drives no ready and never applies back-pressure. A transfer counts only in the cycle where valid and ready are both high. A stalled beat (valid high, ready low) produces nothing, however long it waits, and it is counted once when it finally completes. Configuration comes from two 32-bit register values held elsewhere. The control register carries the enables and the mask, and the match register carries the reference ID.

Top module: `axf_event_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all three event outputs are low.
- R2: An address-read handshake whose ID matches, with control bit 31 set, makes `evt_rd_txn` high for exactly the next cycle.
- R3: An address-write handshake whose ID matches, with control bit 30 set, makes `evt_wr_txn` high for exactly the next cycle.
- R4: Every read-data handshake whose ID matches, with control bit 29 set, makes `evt_rd_beat` high in the next cycle. This holds for every beat of a burst, the last one included.
- R5: An ID matches when ((ID XOR match[17:0]) AND control[17:0]) is zero. A mask bit of 1 compares that ID bit, a mask bit of 0 ignores it, and an all-zero mask matches every ID.
- R6: A cycle with valid high and ready low, or ready high and valid low, produces no pulse on that channel's output in the next cycle.
- R7: With a channel's enable bit clear, its output stays low whatever the traffic.
- R8: Back-to-back handshakes on one channel give back-to-back pulses, one per handshake, with no merging or gaps.
- R9: The three channels are independent. Handshakes in the same cycle on several channels give pulses in the same following cycle.
- R10: Control bits 28:18 and match bits 31:18 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 32 | Bit 31 read-txn enable, bit 30 write-txn enable, bit 29 read-beat enable, bits 17:0 ID mask |
| cfg_match | input | 32 | Bits 17:0 reference ID |
| ar_valid | input | 1 | Address-read valid (tap) |
| ar_ready | input | 1 | Address-read ready (tap) |
| ar_id | input | 18 | Address-read ID |
| aw_valid | input | 1 | Address-write valid (tap) |
| aw_ready | input | 1 | Address-write ready (tap) |
| aw_id | input | 18 | Address-write ID |
| r_valid | input | 1 | Read-data valid (tap) |
| r_ready | input | 1 | Read-data ready (tap) |
| r_id | input | 18 | Read-data ID |
| evt_rd_txn | output | 1 | Filtered read-transaction pulse (counter 2) |
| evt_wr_txn | output | 1 | Filtered write-transaction pulse (counter 3) |
| evt_rd_beat | output | 1 | Filtered read-beat pulse (counter 4) |

## Verification
The bench first drives exact-match IDs with a full mask, which shows that each channel reaches its own output and no other. It then uses partial and zero masks with IDs that differ only in ignored bits or only in compared bits, which separates the mask from the reference ID. Stalled valid, unmatched ready, cleared enables and junk in the unused register bits check that no pulse appears where none is due. Long bursts, simultaneous traffic and a random mix of IDs, masks and handshakes expose merged, dropped or cross-wired pulses.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int unsigned NCH = 3;
  typedef enum logic [1:0] {
    CH_RD_TXN  = 2'd0,
    CH_WR_TXN  = 2'd1,
    CH_RD_BEAT = 2'd2
  } axf_ch_e;
  // Enable bit of channel k sits at EN_TOP - k in the control register.
  localparam int unsigned EN_TOP = 31;
endpackage

// File: rtl/axf_id_match.sv
module axf_id_match #(
  parameter int unsigned ID_W = 18
) (
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] ref_id,
  input  logic [ID_W-1:0] mask,
  input  logic            enable,
  output logic            hit
);
  logic [ID_W-1:0] diff;
  always_comb begin
    diff = (id ^ ref_id) & mask;
    hit  = enable && valid && ready && (diff == '0);
  end
endmodule

// File: rtl/axf_pulse_reg.sv
module axf_pulse_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/axf_event_filter.sv
module axf_event_filter #(
  parameter int unsigned ID_W  = 18,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cfg_ctrl,
  input  logic [REG_W-1:0] cfg_match,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic [ID_W-1:0]  aw_id,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  output logic             evt_rd_txn,
  output logic             evt_wr_txn,
  output logic             evt_rd_beat
);
  import axf_pkg::*;
  localparam int unsigned EN_LO = EN_TOP - NCH + 1;

  logic [NCH-1:0]  ch_valid, ch_ready, ch_en, ch_hit, ch_evt;
  logic [ID_W-1:0] ch_id [NCH];
  logic            unused_cfg;

  assign unused_cfg = ^{cfg_ctrl[EN_LO-1:ID_W], cfg_match[REG_W-1:ID_W]};

  always_comb begin
    ch_valid[CH_RD_TXN]  = ar_valid;
    ch_ready[CH_RD_TXN]  = ar_ready;
    ch_id[CH_RD_TXN]     = ar_id;
    ch_valid[CH_WR_TXN]  = aw_valid;
    ch_ready[CH_WR_TXN]  = aw_ready;
    ch_id[CH_WR_TXN]     = aw_id;
    ch_valid[CH_RD_BEAT] = r_valid;
    ch_ready[CH_RD_BEAT] = r_ready;
    ch_id[CH_RD_BEAT]    = r_id;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_en[k] = cfg_ctrl[EN_TOP - k];
    axf_id_match #(.ID_W(ID_W)) u_match (
      .valid  (ch_valid[k]),
      .ready  (ch_ready[k]),
      .id     (ch_id[k]),
      .ref_id (cfg_match[ID_W-1:0]),
      .mask   (cfg_ctrl[ID_W-1:0]),
      .enable (ch_en[k]),
      .hit    (ch_hit[k])
    );
  end

  axf_pulse_reg #(.N(NCH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ch_hit),
    .q     (ch_evt)
  );

  assign evt_rd_txn  = ch_evt[CH_RD_TXN];
  assign evt_wr_txn  = ch_evt[CH_WR_TXN];
  assign evt_rd_beat = ch_evt[CH_RD_BEAT];
endmodule

// File: rtl/axf_event_filter_chk.sv
module axf_event_filter_chk #(
  parameter int unsigned ID_W  = 18,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] cfg_ctrl,
  input logic [REG_W-1:0] cfg_match,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic [ID_W-1:0]  ar_id,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic [ID_W-1:0]  aw_id,
  input logic             r_valid,
  input logic             r_ready,
  input logic [ID_W-1:0]  r_id,
  input logic             evt_rd_txn,
  input logic             evt_wr_txn,
  input logic             evt_rd_beat
);
  logic ar_m, aw_m, r_m;
  assign ar_m = ((ar_id ^ cfg_match[ID_W-1:0]) & cfg_ctrl[ID_W-1:0]) == '0;
  assign aw_m = ((aw_id ^ cfg_match[ID_W-1:0]) & cfg_ctrl[ID_W-1:0]) == '0;
  assign r_m  = ((r_id  ^ cfg_match[ID_W-1:0]) & cfg_ctrl[ID_W-1:0]) == '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!evt_rd_txn && !evt_wr_txn && !evt_rd_beat);
    end
  end

  assert_rd_txn_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready && cfg_ctrl[31] && ar_m) |=> evt_rd_txn);
  assert_wr_txn_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && cfg_ctrl[30] && aw_m) |=> evt_wr_txn);
  assert_rd_beat_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && cfg_ctrl[29] && r_m) |=> evt_rd_beat);
  assert_mismatch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_m |=> !evt_rd_txn);
  assert_no_hs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_valid && r_ready) |=> !evt_rd_beat);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctrl[30] |=> !evt_wr_txn);
endmodule

bind axf_event_filter axf_event_filter_chk #(.ID_W(ID_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_match(cfg_match),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
  .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
  .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
);

// File: tb/sim_axf_event_filter.sv
`timescale 1ns/1ps
module sim_axf_event_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ctrl = '0, cfg_match = '0;
  logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0, r_valid = 0, r_ready = 0;
  logic [17:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic        evt_rd_txn, evt_wr_txn, evt_rd_beat;
  int          n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  axf_event_filter u0 (.*);

  initial begin
    #(4ns * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung (got timeout, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic bit id_ok(logic [17:0] id);
    return ((id ^ cfg_match[17:0]) & cfg_ctrl[17:0]) == 18'd0;
  endfunction

  task automatic chk(string req, string nm, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %b expected %b at %0t", req, nm, got, exp, $time);
    end
  endtask

  // Called just after a negedge: drive, wait one edge, compare at next negedge.
  task automatic tick(string req,
                      logic av, logic ar, logic [17:0] ai,
                      logic wv, logic wr, logic [17:0] wi,
                      logic rv, logic rr, logic [17:0] ri);
    bit e_rt, e_wt, e_rb;
    ar_valid = av; ar_ready = ar; ar_id = ai;
    aw_valid = wv; aw_ready = wr; aw_id = wi;
    r_valid  = rv; r_ready  = rr; r_id  = ri;
    e_rt = av && ar && cfg_ctrl[31] && id_ok(ai);
    e_wt = wv && wr && cfg_ctrl[30] && id_ok(wi);
    e_rb = rv && rr && cfg_ctrl[29] && id_ok(ri);
    @(negedge clk);
    chk(req, "evt_rd_txn", evt_rd_txn, e_rt);
    chk(req, "evt_wr_txn", evt_wr_txn, e_wt);
    chk(req, "evt_rd_beat", evt_rd_beat, e_rb);
  endtask

  task automatic idle(string req);
    tick(req, 0,0,0, 0,0,0, 0,0,0);
  endtask

  initial begin
    cfg_ctrl = 32'hE003_FFFF; cfg_match = 32'h0001_2345;
    ar_valid = 1; ar_ready = 1; ar_id = 18'h12345;
    repeat (3) @(negedge clk);
    chk("R1", "evt_rd_txn", evt_rd_txn, 1'b0);
    chk("R1", "evt_wr_txn", evt_wr_txn, 1'b0);
    chk("R1", "evt_rd_beat", evt_rd_beat, 1'b0);
    ar_valid = 0; ar_ready = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "evt_rd_txn", evt_rd_txn, 1'b0);

    // R2 R3 R4: exact match, full mask, one channel at a time
    tick("R2", 1,1,18'h12345, 0,0,0, 0,0,0);
    idle("R2");
    tick("R3", 0,0,0, 1,1,18'h12345, 0,0,0);
    tick("R4", 0,0,0, 0,0,0, 1,1,18'h12345);
    tick("R5", 1,1,18'h12344, 1,1,18'h32345, 1,1,18'h12355);

    // R5: partial mask ignores low byte
    cfg_ctrl = 32'hE003_FF00;
    tick("R5", 1,1,18'h123AB, 1,1,18'h12300, 1,1,18'h124FF);
    cfg_ctrl = 32'hE000_0000;
    tick("R5", 1,1,18'h3FFFF, 1,1,18'h00000, 1,1,18'h2AAAA);

    // R6: stalls and idle ready
    cfg_ctrl = 32'hE003_FFFF;
    tick("R6", 1,0,18'h12345, 0,1,18'h12345, 1,0,18'h12345);
    tick("R6", 0,1,18'h12345, 1,0,18'h12345, 0,1,18'h12345);
    tick("R6", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);

    // R7: enables cleared one by one
    cfg_ctrl = 32'h6003_FFFF;
    tick("R7", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);
    cfg_ctrl = 32'h0003_FFFF;
    tick("R7", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);

    // R8: read burst of 8 beats, last included, then a gap
    cfg_ctrl = 32'hE003_FFFF;
    for (int i = 0; i < 8; i++) tick("R8", 0,0,0, 0,0,0, 1,1,18'h12345);
    idle("R8");
    for (int i = 0; i < 4; i++) tick("R8", 1,1,18'h12345, 1,1,18'h12345, 0,0,0);

    // R9: simultaneous, independent outcomes
    tick("R9", 1,1,18'h12345, 1,1,18'h00001, 1,1,18'h12345);
    tick("R9", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);

    // R10: junk in unused register bits
    cfg_ctrl = 32'hFFFF_FFFF; cfg_match = 32'hFFFC_2345 | 32'h0001_0000;
    tick("R10", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);
    cfg_ctrl = 32'h1FFC_FFFF;
    tick("R10", 1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        cfg_ctrl  = $urandom;
        cfg_match = $urandom;
      end
      tick("R5", 1'($urandom), 1'($urandom), 18'($urandom) & 18'h3,
                 1'($urandom), 1'($urandom), 18'($urandom) | 18'h3FFF0,
                 1'($urandom), 1'($urandom), 18'(cfg_match[17:0] ^ ($urandom & 3)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule